// File: doc/BRIEF.md
# PCI Bus Arbiter with Two Priority Groups

This block is the central arbiter of a 32-bit parallel PCI bus. It decides which bus master may start the next transaction. One requester is internal (the bridge that hosts the arbiter). The others are external masters, each with an active-low request input and an active-low grant output. Software gives every requester an enable bit and a priority bit, and these split the requesters into a high group and a low group. Within each group the grant rotates round-robin. After each transaction started by a high-priority master, one low-priority master is owed a turn, so the low group cannot starve.

The arbiter watches FRAME_L to see when the granted master has taken the bus. It keeps that grant for a short fixed window, then drops every grant for one clock. It issues a new grant only at a clock edge where FRAME_L is sampled high, which is either an idle bus or the last data phase. When nothing is requesting, the bus is parked on the internal requester. A strap input bypasses the arbiter entirely, so that an external arbiter can drive the bridge's grant.

Top module: `pci_bus_arbiter`

## Requirements
- R1: A requester whose enable bit is 0 is never granted. Requester index 0 is the internal requester and index i (i >= 1) is external input req_n_ext[i-1]; req_en[i] and req_hi[i] belong to index i.
- R2: When the low group is not owed a turn, a pending enabled requester with req_hi = 1 is granted ahead of every pending requester with req_hi = 0.
- R3: When FRAME_L is sampled low at an edge while a grant is asserted, that grant stays asserted for the next HOLD_CLKS clocks (2 by default). All grants are then deasserted for exactly one clock.
- R4: Within a group, the grant goes to the first pending requester found by counting upward with wrap-around from the group member whose transaction started most recently. After reset, both groups start their search at index 0.
- R5: Once a transaction by a high-group owner has started, the next grant goes to a pending low-group requester if there is one. The owed turn is used up when a low-group owner starts a transaction.
- R6: At most one grant is asserted in any clock. A grant that changes to a new requester appears only after an edge where FRAME_L was high. An edge where FRAME_L is low and no transaction is being taken leaves all grants deasserted.
- R7: At an edge with FRAME_L high, no enabled request, req_en[0] = 1 and no hold in progress, the next grant is parked on the internal requester (int_gnt = 1).
- R8: While ext_arb_mode = 1, every gnt_n_ext bit is 1 and int_gnt equals the inverse of req_n_ext[0], which then serves as the grant input.
- R9: par_drive is 1 exactly when int_gnt = 1 and both FRAME_L and IRDY_L are high.
- R10: While rst_n is low, all grants are deasserted (int_gnt = 0, gnt_n_ext all ones).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_arb_mode | input | 1 | Strap: 1 bypasses the arbiter for an external one |
| req_en | input | NUM_EXT+1 | Per-requester enable, bit 0 internal |
| req_hi | input | NUM_EXT+1 | Per-requester priority, 1 = high group |
| int_req | input | 1 | Internal requester's request, active high |
| req_n_ext | input | NUM_EXT | External requests, active low; bit 0 is the grant input in external mode |
| frame_n | input | 1 | Bus FRAME_L |
| irdy_n | input | 1 | Bus IRDY_L |
| int_gnt | output | 1 | Grant to the internal requester, active high |
| gnt_n_ext | output | NUM_EXT | External grants, active low |
| par_drive | output | 1 | The bridge drives PAR while the bus is parked on it and idle |

## Verification
The bench builds the arbiter with NUM_EXT = 3 (four requesters) and HOLD_CLKS = 2. With so few requesters, wrap-around in both rotation pointers, the owed low-group turn and parking all happen within a few transactions. Directed sequences pin down the hold-and-gap timing, the priority override and external mode. Seeded random requests, enables, priorities and FRAME_L activity that follows the grants then exercise the interleavings of these cases.

// File: rtl/pci_bus_arbiter.sv
module pci_bus_arbiter #(
  parameter int NUM_EXT   = 6,
  parameter int HOLD_CLKS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_arb_mode,
  input  logic [NUM_EXT:0]   req_en,
  input  logic [NUM_EXT:0]   req_hi,
  input  logic               int_req,
  input  logic [NUM_EXT-1:0] req_n_ext,
  input  logic               frame_n,
  input  logic               irdy_n,
  output logic               int_gnt,
  output logic [NUM_EXT-1:0] gnt_n_ext,
  output logic               par_drive
);
  localparam int N  = NUM_EXT + 1;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(HOLD_CLKS + 1);

  typedef enum logic [1:0] {S_ARB, S_HOLD, S_GAP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [N-1:0]  gnt_q, nxt_gnt, reqs, hi_v, lo_v;
  logic [IW-1:0] last_hi, last_lo, hi_idx, lo_idx, own_idx;
  logic          hi_ok, lo_ok, lo_turn;

  function automatic logic [IW:0] rr_pick(input logic [N-1:0] v, input logic [IW-1:0] last);
    logic [IW:0] res;
    res = '0;
    for (int k = N; k >= 1; k--) begin
      int j;
      j = (int'(last) + k) % N;
      if (v[j]) res = {1'b1, IW'(j)};
    end
    return res;
  endfunction

  assign reqs = req_en & {~req_n_ext, int_req};
  assign hi_v = reqs & req_hi;
  assign lo_v = reqs & ~req_hi;
  assign {hi_ok, hi_idx} = rr_pick(hi_v, last_hi);
  assign {lo_ok, lo_idx} = rr_pick(lo_v, last_lo);

  always_comb begin
    nxt_gnt = '0;
    if (lo_turn && lo_ok)  nxt_gnt[lo_idx] = 1'b1;
    else if (hi_ok)        nxt_gnt[hi_idx] = 1'b1;
    else if (lo_ok)        nxt_gnt[lo_idx] = 1'b1;
    else if (req_en[0])    nxt_gnt[0] = 1'b1;
  end

  always_comb begin
    own_idx = '0;
    for (int i = 0; i < N; i++)
      if (gnt_q[i]) own_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_ARB;
      cnt     <= '0;
      gnt_q   <= '0;
      last_hi <= IW'(N - 1);
      last_lo <= IW'(N - 1);
      lo_turn <= 1'b0;
    end else if (ext_arb_mode) begin
      st    <= S_ARB;
      gnt_q <= '0;
    end else if (st == S_HOLD) begin
      if (cnt == '0) begin
        st    <= S_GAP;
        gnt_q <= '0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (st == S_ARB && |gnt_q && !frame_n) begin
      st  <= S_HOLD;
      cnt <= CW'(HOLD_CLKS - 1);
      if (req_hi[own_idx]) begin
        last_hi <= own_idx;
        lo_turn <= 1'b1;
      end else begin
        last_lo <= own_idx;
        lo_turn <= 1'b0;
      end
    end else begin
      st    <= S_ARB;
      gnt_q <= frame_n ? nxt_gnt : '0;
    end
  end

  assign int_gnt   = ext_arb_mode ? ~req_n_ext[0] : gnt_q[0];
  assign gnt_n_ext = ext_arb_mode ? '1 : ~gnt_q[N-1:1];
  assign par_drive = int_gnt & frame_n & irdy_n;

  p_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_arb_mode |=> ((gnt_q & ~$past(gnt_q) & ~$past(req_en)) == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_arb_mode && st == S_ARB && |gnt_q && !frame_n) |=> (gnt_q == $past(gnt_q)));

  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n || ext_arb_mode)
    (st == S_GAP) |-> (&gnt_n_ext && !int_gnt));

  p_one_r6: assert property (@(posedge clk) disable iff (!rst_n || ext_arb_mode)
    $onehot0({~gnt_n_ext, int_gnt}));

  p_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_arb_mode && !frame_n) |=> (gnt_q == '0 || gnt_q == $past(gnt_q)));

  p_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_arb_mode && st != S_HOLD && frame_n && reqs == '0 && req_en[0]) |=> gnt_q[0]);

  p_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_arb_mode |=> (gnt_q == '0));
endmodule

// File: tb/pci_bus_arbiter_bench.sv
`timescale 1ns/1ps
module pci_bus_arbiter_bench;
  localparam int NE = 3;
  localparam int N  = NE + 1;
  localparam int HC = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, ext_arb_mode, int_req, frame_n, irdy_n;
  logic [N-1:0]  req_en, req_hi;
  logic [NE-1:0] req_n_ext;
  logic          int_gnt, par_drive;
  logic [NE-1:0] gnt_n_ext;

  logic          nx_rst, nx_ext, nx_ireq, nx_frame, nx_irdy;
  logic [N-1:0]  nx_en, nx_hi;
  logic [NE-1:0] nx_req;

  int checks = 0, fails = 0;
  bit done = 0;

  pci_bus_arbiter #(.NUM_EXT(NE), .HOLD_CLKS(HC)) u_pci_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .ext_arb_mode(ext_arb_mode), .req_en(req_en),
    .req_hi(req_hi), .int_req(int_req), .req_n_ext(req_n_ext), .frame_n(frame_n),
    .irdy_n(irdy_n), .int_gnt(int_gnt), .gnt_n_ext(gnt_n_ext), .par_drive(par_drive));

  int m_st, m_cnt, m_gnt, m_lhi, m_llo;
  bit m_lot;

  function automatic int rr(input logic [N-1:0] v, input int last);
    for (int k = 1; k <= N; k++) if (v[(last + k) % N]) return (last + k) % N;
    return -1;
  endfunction

  task automatic model_step();
    logic [N-1:0] r;
    int w;
    r = req_en & {~req_n_ext, int_req};
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_gnt = -1; m_lhi = N-1; m_llo = N-1; m_lot = 0;
    end else if (ext_arb_mode) begin
      m_st = 0; m_gnt = -1;
    end else if (m_st == 1) begin
      if (m_cnt == 0) begin m_st = 2; m_gnt = -1; end
      else m_cnt--;
    end else if (m_st == 0 && m_gnt >= 0 && !frame_n) begin
      m_st = 1; m_cnt = HC - 1;
      if (req_hi[m_gnt]) begin m_lhi = m_gnt; m_lot = 1; end
      else begin m_llo = m_gnt; m_lot = 0; end
    end else begin
      m_st = 0;
      if (!frame_n) m_gnt = -1;
      else begin
        w = -1;
        if (m_lot) w = rr(r & ~req_hi, m_llo);
        if (w < 0) w = rr(r & req_hi, m_lhi);
        if (w < 0) w = rr(r & ~req_hi, m_llo);
        if (w < 0 && req_en[0]) w = 0;
        m_gnt = w;
      end
    end
  endtask

  task automatic cmp(input string tag);
    logic e_int, e_par;
    logic [NE-1:0] e_ext;
    e_int = ext_arb_mode ? !req_n_ext[0] : (m_gnt == 0);
    for (int i = 0; i < NE; i++) e_ext[i] = ext_arb_mode ? 1'b1 : !(m_gnt == i + 1);
    e_par = e_int & frame_n & irdy_n;
    checks++;
    if (int_gnt !== e_int || gnt_n_ext !== e_ext || par_drive !== e_par) begin
      fails++;
      $display("FAIL %s: got int=%b ext=%b par=%b exp int=%b ext=%b par=%b",
               tag, int_gnt, gnt_n_ext, par_drive, e_int, e_ext, e_par);
    end
  endtask

  task automatic chk(input string tag, input logic [NE:0] exp);
    checks++;
    if ({int_gnt, gnt_n_ext} !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, {int_gnt, gnt_n_ext}, exp);
    end
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    model_step();
    rst_n = nx_rst; ext_arb_mode = nx_ext; req_en = nx_en; req_hi = nx_hi;
    int_req = nx_ireq; req_n_ext = nx_req; frame_n = nx_frame; irdy_n = nx_irdy;
    #1;
    cmp(tag);
  endtask

  task automatic txn(input string tag);
    nx_frame = 0; nx_irdy = 0; step(tag);
    step(tag); step(tag);
    nx_frame = 1; step(tag);
    nx_irdy = 1; step(tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, fails);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    summary();
    $finish;
  end

  initial begin
    int bsy;
    bit lastph;
    void'($urandom(1234));
    nx_rst = 0; nx_ext = 0; nx_en = '1; nx_hi = '0; nx_ireq = 0; nx_req = '1;
    nx_frame = 1; nx_irdy = 1;
    rst_n = 0; ext_arb_mode = 0; req_en = '1; req_hi = '0; int_req = 0;
    req_n_ext = '1; frame_n = 1; irdy_n = 1;
    repeat (3) step("R10");
    chk("R10 reset grants off", 4'b0111);
    nx_rst = 1; step("R10"); step("R7");
    chk("R7 parked on internal", 4'b1111);
    if (par_drive !== 1'b1) begin fails++; $display("FAIL R9: got par=%b expected 1", par_drive); end
    checks++;
    nx_irdy = 0; step("R9");
    checks++;
    if (par_drive !== 1'b0) begin fails++; $display("FAIL R9: got par=%b expected 0", par_drive); end
    nx_irdy = 1;
    // R1: index 2 disabled and the only requester
    nx_en = 4'b1011; nx_req = 3'b101; step("R1"); step("R1");
    chk("R1 disabled not granted", 4'b1111);
    step("R1"); chk("R1 disabled still not granted", 4'b1111);
    // R2: index 3 high, index 1 low
    nx_en = '1; nx_hi = 4'b1000; nx_req = 3'b010; step("R2"); step("R2");
    chk("R2 high group wins", 4'b0011);
    // R3 hold and gap
    nx_frame = 0; nx_irdy = 0; step("R3");
    step("R3"); chk("R3 hold clock 1", 4'b0011);
    step("R3"); chk("R3 hold clock 2", 4'b0011);
    step("R3"); chk("R3 gap clock", 4'b0111);
    step("R6"); chk("R6 no grant while FRAME_L low", 4'b0111);
    nx_frame = 1; step("R6");
    nx_irdy = 1; step("R5");
    chk("R5 owed low turn", 4'b0110);
    txn("R5");
    chk("R5 turn used, high again", 4'b0011);
    nx_hi = '0; nx_req = 3'b000; step("R4"); step("R4");
    chk("R4 rotate after index 1", 4'b0101);
    txn("R4"); chk("R4 rotate to index 3", 4'b0011);
    txn("R4"); chk("R4 wrap to index 1", 4'b0110);
    // R8 external arbiter mode
    nx_ext = 1; nx_req = 3'b110; step("R8");
    chk("R8 external grant in", 4'b1111);
    nx_req = 3'b111; step("R8");
    chk("R8 external grant off", 4'b0111);
    nx_ext = 0; step("R8"); step("R8");
    // random phase
    bsy = 0; lastph = 0;
    for (int c = 0; c < 4000; c++) begin
      if (c % 64 == 0) begin
        nx_en = N'($urandom) | N'($urandom);
        nx_hi = N'($urandom) & N'($urandom);
      end
      nx_ireq = ($urandom % 4) == 0;
      nx_req = NE'($urandom) | NE'($urandom);
      nx_ext = (c >= 2000 && c < 2150);
      if (bsy > 0) begin
        nx_frame = 0; nx_irdy = 0; bsy--;
        if (bsy == 0) lastph = 1;
      end else if (lastph) begin
        nx_frame = 1; nx_irdy = 0; lastph = 0;
      end else begin
        nx_frame = 1; nx_irdy = 1;
        if (!ext_arb_mode && m_st == 0 && m_gnt >= 0 && ($urandom % 3) == 0) begin
          nx_frame = 0; nx_irdy = 0;
          bsy = $urandom % 3;
          if (bsy == 0) lastph = 1;
        end
      end
      step("R4");
    end
    summary();
    $finish;
  end
endmodule